// File: doc/BRIEF.md
# Temperature Alarm Output Controller

This block watches a stream of digital temperature samples and decides when to pull a shared, active-low alarm line. It holds three limits: a lower limit, an upper limit and a critical limit. It also holds a hysteresis setting and a mode selection. Software programs all of these through a small write port. The line is never driven high. The block exposes an output enable: when it is 1, the pad pulls the line low. Otherwise the line floats and an external pull-up holds it high.

Samples are 11-bit two's-complement values in quarter-degree steps. The three limits use the same format. The block evaluates a sample only in a cycle where the sample-valid strobe is high.

There are three ways to use the alarm:
- **Latched mode**: an alarm waits until software acknowledges it.
- **Tracking mode**: the alarm follows the temperature and clears by itself once the temperature is back inside the window with margin.
- **Critical-only mode**: the alarm watches nothing but the critical limit.

In every mode, a critical excursion overrides software. It holds the line low until the temperature has dropped below the critical limit by the hysteresis margin, and the acknowledge strobe cannot release it.

Top module: `temp_alert_ctrl`

## Requirements
- R1: After reset the output enable is 0, the limits are lower = -1024, upper = +1023 and critical = +1023 (quarter steps), and the configuration is all zeros (latched mode, window off, no hysteresis).
- R2: A write with `wr_sel` = 0, 1, 2 loads the lower, upper and critical limit from `wr_data`. With `wr_sel` = 3, `wr_data[1:0]` is the mode (0 latched, 1 tracking, 2 or 3 critical-only), bit 2 enables the window and bits [4:3] are the hysteresis code. No other input changes a register.
- R3: With the window enabled, a valid sample below the lower limit or above the upper limit raises the window alarm. Samples are evaluated only when `samp_valid` is 1, and the output reflects a sample right after the clock edge that takes it.
- R4: In latched mode a window alarm stays asserted until `evt_clr` is sampled high, and it is released at that same edge.
- R5: In tracking mode `evt_clr` has no effect. The window alarm is released only by a valid sample that lies at or above lower + H and at or below upper - H.
- R6: In critical-only mode the window limits never affect the output. The output is asserted only through the critical alarm.
- R7: In every mode, a valid sample above the critical limit asserts the output. The output then stays asserted, whatever `evt_clr` does, until a valid sample is at or below critical - H.
- R8: The hysteresis margin H in quarter steps is 0, 6, 12 or 24 for codes 0 to 3, that is 0, 1.5, 3 or 6 degrees.
- R9: While the window is disabled the window limits never trip. A valid sample taken with the window disabled clears a pending tracking-mode window alarm.
- R10: In latched mode, when a tripping sample and `evt_clr` arrive in the same cycle, the alarm stays asserted.
- R11: Trip comparisons are strict. A sample equal to a limit does not trip it.
- R12: A register write takes effect at its clock edge. A sample taken in the same cycle is judged against the limits held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_valid | input | 1 | Sample strobe; `samp_temp` is evaluated in this cycle |
| samp_temp | input | 11 | Temperature sample, signed, 0.25 degree per LSB |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 lower, 1 upper, 2 critical, 3 configuration |
| wr_data | input | 11 | Write data |
| evt_clr | input | 1 | Software acknowledge of a latched alarm |
| alert_oe | output | 1 | 1 = pull the alarm line low, 0 = release it |

## Verification
Two functions can fall in the same cycle.

- **Acknowledge against a new excursion.** In latched mode the bench raises `evt_clr` on the edge where an out-of-window sample arrives, and expects the line to stay low. It also raises the acknowledge while a critical excursion is active, and expects the line to remain low.
- **Write against an evaluated sample.** The bench rewrites a limit in the same cycle as a sample that would trip only against the new value. It expects the old limit to decide that sample and the new one to decide the next.

A behavioural model computes the expected output at every clock. Directed sequences are followed by a long mix of random samples, writes and acknowledges.

// File: rtl/temp_alert_pkg.sv
package temp_alert_pkg;

  typedef enum logic [1:0] {
    MODE_LATCH    = 2'd0,
    MODE_TRACK    = 2'd1,
    MODE_CRIT     = 2'd2,
    MODE_CRIT_ALT = 2'd3
  } alert_mode_e;

  typedef enum logic [1:0] {
    SEL_LOWER = 2'd0,
    SEL_UPPER = 2'd1,
    SEL_CRIT  = 2'd2,
    SEL_CFG   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [1:0]  hyst;
    logic        win_en;
    alert_mode_e mode;
  } alert_cfg_t;

  localparam int CFG_W = $bits(alert_cfg_t);

  // release margin in quarter-degree steps
  function automatic int unsigned hyst_quarters(input logic [1:0] code);
    case (code)
      2'd0:    return 0;
      2'd1:    return 6;
      2'd2:    return 12;
      default: return 24;
    endcase
  endfunction

  function automatic logic is_crit_only(input alert_mode_e m);
    return (m == MODE_CRIT) || (m == MODE_CRIT_ALT);
  endfunction

endpackage

// File: rtl/ta_regfile.sv
module ta_regfile
  import temp_alert_pkg::*;
#(
  parameter int TW   = 11,
  parameter int NLIM = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [1:0]               wr_sel,
  input  logic [TW-1:0]            wr_data,
  output logic [NLIM-1:0][TW-1:0]  lim_o,
  output alert_cfg_t               cfg_o
);

  localparam logic [TW-1:0] LIM_MIN = {1'b1, {(TW-1){1'b0}}};
  localparam logic [TW-1:0] LIM_MAX = {1'b0, {(TW-1){1'b1}}};

  for (genvar g = 0; g < NLIM; g++) begin : g_lim
    localparam logic [TW-1:0] RST_VAL = (g == int'(SEL_LOWER)) ? LIM_MIN : LIM_MAX;
    logic hit;
    assign hit = wr_en && (wr_sel == 2'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lim_o[g] <= RST_VAL;
      else if (hit) lim_o[g] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cfg_o <= '0;
    else if (wr_en && (wr_sel == SEL_CFG))
      cfg_o <= alert_cfg_t'(wr_data[CFG_W-1:0]);
  end

  AST_LIMITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(lim_o)) else $error("limits changed without write"); // R2
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_sel != SEL_CFG) |=> $stable(cfg_o)) else $error("config changed without write"); // R2

endmodule

// File: rtl/ta_thresh_cmp.sv
module ta_thresh_cmp #(
  parameter int TW    = 11,
  parameter bit UPPER = 1'b1
) (
  input  logic [TW-1:0]        temp,
  input  logic [TW-1:0]        limit,
  input  logic signed [TW+1:0] hyst,
  output logic                 trip,
  output logic                 rel
);

  logic signed [TW+1:0] t_x;
  logic signed [TW+1:0] l_x;

  assign t_x = {{2{temp[TW-1]}}, temp};
  assign l_x = {{2{limit[TW-1]}}, limit};

  if (UPPER) begin : g_upper
    assign trip = t_x > l_x;
    assign rel  = t_x <= (l_x - hyst);
  end else begin : g_lower
    assign trip = t_x < l_x;
    assign rel  = t_x >= (l_x + hyst);
  end

endmodule

// File: rtl/ta_event_state.sv
module ta_event_state
  import temp_alert_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        samp_valid,
  input  logic        evt_clr,
  input  alert_mode_e mode,
  input  logic        win_en,
  input  logic        win_trip,
  input  logic        win_rel,
  input  logic        crit_trip,
  input  logic        crit_rel,
  output logic        alert_oe
);

  logic win_act;
  logic crit_act;
  logic irq_lat;
  logic win_fire;

  assign win_fire = samp_valid && win_en && win_trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_act  <= 1'b0;
      crit_act <= 1'b0;
    end else if (samp_valid) begin
      if (crit_trip)     crit_act <= 1'b1;
      else if (crit_rel) crit_act <= 1'b0;

      if (!win_en)       win_act <= 1'b0;
      else if (win_trip) win_act <= 1'b1;
      else if (win_rel)  win_act <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  irq_lat <= 1'b0;
    else if (mode != MODE_LATCH) irq_lat <= 1'b0;
    else if (win_fire)           irq_lat <= 1'b1;
    else if (evt_clr)            irq_lat <= 1'b0;
  end

  always_comb begin
    if (is_crit_only(mode))      alert_oe = crit_act;
    else if (mode == MODE_TRACK) alert_oe = crit_act | win_act;
    else                         alert_oe = crit_act | irq_lat;
  end

  AST_WIN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    win_fire |=> win_act) else $error("window trip lost"); // R3
  AST_LATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LATCH && evt_clr && !win_fire) |=> !irq_lat) else $error("acknowledge ignored"); // R4
  AST_TRACK_NO_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (win_act && !samp_valid) |=> win_act) else $error("window alarm dropped without sample"); // R5
  AST_CRIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_valid && crit_trip) |=> crit_act) else $error("critical trip lost"); // R7
  AST_CRIT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (crit_act && !samp_valid) |=> alert_oe) else $error("critical alarm released"); // R7
  AST_WIN_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_valid && !win_en) |=> !win_act) else $error("window alarm with window off"); // R9
  AST_TRIP_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LATCH && win_fire && evt_clr) |=> irq_lat) else $error("acknowledge beat trip"); // R10

endmodule

// File: rtl/temp_alert_ctrl.sv
module temp_alert_ctrl
  import temp_alert_pkg::*;
#(
  parameter int TW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          samp_valid,
  input  logic [TW-1:0] samp_temp,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [TW-1:0] wr_data,
  input  logic          evt_clr,
  output logic          alert_oe
);

  localparam int NLIM = 3;
  localparam int EW   = TW + 2;

  logic [NLIM-1:0][TW-1:0] lim;
  alert_cfg_t              cfg;
  logic signed [EW-1:0]    hyst_q;
  logic [NLIM-1:0]         trip;
  logic [NLIM-1:0]         rel;

  ta_regfile #(.TW(TW), .NLIM(NLIM)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .lim_o   (lim),
    .cfg_o   (cfg)
  );

  assign hyst_q = EW'(hyst_quarters(cfg.hyst));

  // index 0 is the lower limit; the others are upper-type limits
  for (genvar g = 0; g < NLIM; g++) begin : g_cmp
    ta_thresh_cmp #(.TW(TW), .UPPER(g != int'(SEL_LOWER))) u_cmp (
      .temp  (samp_temp),
      .limit (lim[g]),
      .hyst  (hyst_q),
      .trip  (trip[g]),
      .rel   (rel[g])
    );
  end

  ta_event_state u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_valid (samp_valid),
    .evt_clr    (evt_clr),
    .mode       (cfg.mode),
    .win_en     (cfg.win_en),
    .win_trip   (trip[SEL_LOWER] | trip[SEL_UPPER]),
    .win_rel    (rel[SEL_LOWER] & rel[SEL_UPPER]),
    .crit_trip  (trip[SEL_CRIT]),
    .crit_rel   (rel[SEL_CRIT]),
    .alert_oe   (alert_oe)
  );

  AST_CRITONLY_IGNORES_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (is_crit_only(cfg.mode) && !samp_valid && !wr_en && !alert_oe) |=> !alert_oe)
    else $error("critical-only output rose without sample"); // R6

endmodule

// File: tb/test_temp_alert_ctrl.sv
module test_temp_alert_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        samp_valid = 1'b0;
  logic [10:0] samp_temp = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [10:0] wr_data = '0;
  logic        evt_clr = 1'b0;
  logic        alert_oe;

  int n_vec = 0;
  int n_bad = 0;

  // reference model state
  int m_lo = -1024, m_hi = 1023, m_cr = 1023, m_mode = 0, m_hc = 0;
  bit m_wen = 0, m_win = 0, m_crt = 0, m_irq = 0;

  always #4 clk = ~clk;

  temp_alert_ctrl i_temp_alert_ctrl (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_temp(samp_temp),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .evt_clr(evt_clr),
    .alert_oe(alert_oe)
  );

  function automatic int margin(int code);
    return (code == 0) ? 0 : (6 << (code - 1));
  endfunction

  function automatic bit model_out();
    if (m_mode >= 2) return m_crt;
    if (m_mode == 1) return m_win | m_crt;
    return m_irq | m_crt;
  endfunction

  function automatic int cfgw(int mode, int wen, int hc);
    return hc * 8 + wen * 4 + mode;
  endfunction

  task automatic check(string tag, bit act, bit exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: alert_oe=%0b expected %0b at vector %0d", tag, act, exp, n_vec);
    end
  endtask

  task automatic model_edge(bit sv, int t, bit clr, bit we, int sel, int d);
    int h;
    bit out_win;
    h = margin(m_hc);
    out_win = m_wen && (t < m_lo || t > m_hi);
    if (m_mode != 0) m_irq = 0;
    else if (sv && out_win) m_irq = 1;
    else if (clr) m_irq = 0;
    if (sv) begin
      if (t > m_cr) m_crt = 1;
      else if (t <= m_cr - h) m_crt = 0;
      if (!m_wen) m_win = 0;
      else if (out_win) m_win = 1;
      else if (t >= m_lo + h && t <= m_hi - h) m_win = 0;
    end
    if (we) begin
      case (sel)
        0: m_lo = d;
        1: m_hi = d;
        2: m_cr = d;
        default: begin
          m_mode = d & 3;
          m_wen  = d[2];
          m_hc   = (d >> 3) & 3;
        end
      endcase
    end
  endtask

  task automatic step(string tag, bit sv, int t, bit clr, bit we = 0, int sel = 0, int d = 0);
    @(negedge clk);
    samp_valid = sv;
    samp_temp  = t[10:0];
    evt_clr    = clr;
    wr_en      = we;
    wr_sel     = 2'(sel);
    wr_data    = d[10:0];
    @(posedge clk);
    model_edge(sv, t, clr, we, sel, d);
    #1;
    check(tag, alert_oe, model_out());
    samp_valid = 0; evt_clr = 0; wr_en = 0;
  endtask

  task automatic wr(string tag, int sel, int d);
    step(tag, 0, 0, 0, 1, sel, d);
  endtask

  task automatic smp(string tag, int t, bit clr = 0);
    step(tag, 1, t, clr);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1", alert_oe, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    // R1: defaults never trip at the extremes
    smp("R1", 1023);
    smp("R1", -1024);
    smp("R1", 100);

    // R2/R3/R4/R11/R10 in latched mode
    wr("R2", 0, 0);
    wr("R2", 1, 200);
    wr("R2", 3, cfgw(0, 1, 0));
    smp("R3", 100);
    smp("R3", 201);
    smp("R4", 100);
    step("R4", 0, 0, 1);
    smp("R11", 200);
    smp("R11", 0);
    smp("R3", -1);
    smp("R10", -5, 1);
    smp("R10", 100);
    step("R4", 0, 0, 1);

    // R5/R8 tracking mode, hysteresis code 2 (12 quarters)
    wr("R2", 3, cfgw(1, 1, 2));
    smp("R5", 100);
    smp("R5", 250);
    step("R5", 0, 0, 1);
    smp("R8", 195);
    smp("R8", 189);
    smp("R8", 188);
    smp("R5", -1);
    smp("R8", 11);
    smp("R8", 12);

    // R9 window disable
    smp("R9", 300);
    wr("R9", 3, cfgw(1, 0, 2));
    smp("R9", 300);
    smp("R9", -300);

    // R6 critical-only with hysteresis code 1
    wr("R2", 2, 400);
    wr("R6", 3, cfgw(2, 1, 1));
    smp("R6", 300);
    smp("R6", -50);
    smp("R6", 400);
    smp("R6", 401);
    step("R7", 0, 0, 1);
    smp("R8", 395);
    smp("R8", 394);
    wr("R6", 3, cfgw(3, 1, 1));
    smp("R6", 450);

    // R7 critical lock in latched mode, hysteresis code 3
    smp("R7", 100);
    wr("R2", 1, 500);
    wr("R7", 3, cfgw(0, 1, 3));
    smp("R7", 450);
    step("R7", 0, 0, 1);
    smp("R7", 380, 1);
    smp("R8", 377);
    smp("R8", 376);

    // R12 write and sample in the same cycle
    step("R12", 1, 300, 0, 1, 1, 100);
    smp("R12", 300);
    step("R12", 0, 0, 1);
    smp("R12", 50);

    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      bit sv, clr, we;
      int sel, d, t;
      sv  = ($urandom % 3) != 0;
      clr = ($urandom % 6) == 0;
      we  = ($urandom % 12) == 0;
      sel = $urandom % 4;
      d   = (sel == 3) ? int'($urandom % 32) : int'($urandom % 1000) - 400;
      t   = int'($urandom % 1000) - 400;
      step("R7", sv, t, clr, we, sel, d);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule